// File: doc/BRIEF.md
# Tiled Surface Address Generator

This block turns a pixel coordinate into the byte offset of that pixel inside a two-dimensional surface. The surface can be stored in one of three layouts. The first is plain row order. The second is built from 4 KiB tiles that are 512 bytes wide and 8 rows tall, with rows laid out one after another inside the tile. The third is built from 4 KiB tiles that are 128 bytes wide and 32 rows tall. Inside each of those tiles, 16-byte column blocks are stacked vertically.

For either tiled layout, an optional address swizzle folds bits 9, 10 and/or 11 of the in-tile offset into bit 6. Bit 6 takes the XOR of the selected bits. The swizzle acts before the tile base is added. Each request also carries the surface pitch in pixels and the pixel size.

The generator takes one request per cycle through a valid/ready handshake. It returns each result a fixed two cycles later, and results leave in the order the requests arrived. An illegal layout, pixel-size or swizzle code raises an error flag on that result and forces its offset to zero. Such a request does not stall the pipeline.

Top module: `tile_addr_gen`

## Requirements
- R1: After a synchronous reset, `out_valid` is low and `in_ready` is high.
- R2: Layout code 0 (linear) gives offset = (y × pitch + x) × B. B is the byte size from size code 0→1, 1→2, 2→4.
- R3: Layout code 1 (wide tiles) uses xb = x × B, in-tile = (y mod 8) × 512 + (xb mod 512), and base = (xb div 512) × 4096 + (y div 8) × pitch × B × 8.
- R4: Layout code 2 (tall tiles) uses in-tile = ((xb mod 128) div 16) × 512 + (y mod 32) × 16 + (xb mod 16), and base = (xb div 128) × 4096 + (y div 32) × pitch × B × 32.
- R5: Swizzle codes select what bit 6 of the in-tile offset is XORed with: 0 none, 1 bit 9, 2 bits 9^10, 3 bits 9^11, 4 bits 9^10^11. The swizzle acts on the in-tile offset before the base is added, in the same way for both tiled layouts.
- R6: In the linear layout, a legal swizzle code has no effect on the offset.
- R7: Layout code 3, size code 3, or swizzle codes 5 to 7 give `out_err` = 1 and `out_off` = 0.
- R8: A request accepted on clock edge k is presented with `out_valid` high after edge k+1, provided `out_ready` is high at edge k+1.
- R9: While `out_valid` is high and `out_ready` is low, the output holds its value. Results leave in input order, and `in_ready` is high whenever `out_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_x | input | COORD_W | Pixel column |
| in_y | input | COORD_W | Pixel row |
| in_pitch | input | PITCH_W | Surface width in pixels |
| in_bpp | input | 2 | Pixel size code (0:1, 1:2, 2:4 bytes) |
| in_layout | input | 2 | Layout code (0 linear, 1 wide tiles, 2 tall tiles) |
| in_swz | input | 3 | Bit-6 swizzle code |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result can be taken |
| out_off | output | OFF_W | Byte offset |
| out_err | output | 1 | Illegal code in the request |

## Verification
The bench tries the same coordinate in the wide-tile layout under all five swizzle codes. The in-tile offset is chosen so that some codes flip bit 6 and others cancel out, which shows that each selected bit set is applied. A tall-tile case with bit 11 set separates the 9^11 and 9^10^11 codes from plain 9. Linear cases at two pixel sizes, and a linear case that carries a swizzle code, show that the pitch and size scaling are right and that the linear layout ignores the swizzle. Separate cases cover an illegal layout, an illegal size and an illegal swizzle code, and a burst under backpressure checks that results hold and keep their order.

// File: rtl/tile_addr_pkg.sv
package tile_addr_pkg;
  localparam logic [1:0] LAYOUT_LINEAR = 2'd0;
  localparam logic [1:0] LAYOUT_WIDE   = 2'd1;
  localparam logic [1:0] LAYOUT_TALL   = 2'd2;

  localparam logic [2:0] SWZ_NONE   = 3'd0;
  localparam logic [2:0] SWZ_B9     = 3'd1;
  localparam logic [2:0] SWZ_B9_10  = 3'd2;
  localparam logic [2:0] SWZ_B9_11  = 3'd3;
  localparam logic [2:0] SWZ_B9_ALL = 3'd4;

  localparam int TILE_LG = 12;

  typedef struct packed {
    logic [1:0] layout;
    logic [2:0] swz;
    logic       err;
  } req_mode_t;
endpackage

// File: rtl/tile_addr_front.sv
module tile_addr_front
  import tile_addr_pkg::*;
#(
  parameter int COORD_W = 14,
  parameter int PITCH_W = 14,
  localparam int XB_W = COORD_W + 2,
  localparam int RB_W = PITCH_W + 2
) (
  input  logic [COORD_W-1:0] x,
  input  logic [PITCH_W-1:0] pitch,
  input  logic [1:0]         bpp,
  input  logic [1:0]         layout,
  input  logic [2:0]         swz,
  output logic [XB_W-1:0]    xbyte,
  output logic [RB_W-1:0]    rowbytes,
  output logic               bad
);
  always_comb begin
    xbyte    = {2'b00, x} << bpp;
    rowbytes = {2'b00, pitch} << bpp;
    bad      = (bpp == 2'd3) || (layout == 2'd3) || (swz > SWZ_B9_ALL);
  end
endmodule

// File: rtl/tile_addr_geom.sv
module tile_addr_geom
  import tile_addr_pkg::*;
#(
  parameter int XB_W     = 16,
  parameter int Y_W      = 14,
  parameter int RB_W     = 16,
  parameter int OFF_W    = 32,
  parameter int SPAN_LG  = 9,
  parameter int ROWS_LG  = 3,
  parameter int BLOCK_LG = 0
) (
  input  logic [XB_W-1:0]    xbyte,
  input  logic [Y_W-1:0]     y,
  input  logic [RB_W-1:0]    rowbytes,
  output logic [TILE_LG-1:0] intile,
  output logic [OFF_W-1:0]   base
);
  logic [OFF_W-1:0] col_idx, row_idx, stride;

  always_comb begin
    col_idx = OFF_W'(xbyte >> SPAN_LG);
    row_idx = OFF_W'(y >> ROWS_LG);
    stride  = OFF_W'(rowbytes) << ROWS_LG;
    base    = (col_idx << TILE_LG) + row_idx * stride;
  end

  generate
    if (BLOCK_LG == 0) begin : g_row_major
      assign intile = {y[ROWS_LG-1:0], xbyte[SPAN_LG-1:0]};
    end else begin : g_col_blocks
      assign intile = {xbyte[SPAN_LG-1:BLOCK_LG], y[ROWS_LG-1:0],
                       xbyte[BLOCK_LG-1:0]};
    end
  endgenerate
endmodule

// File: rtl/tile_addr_swz.sv
module tile_addr_swz
  import tile_addr_pkg::*;
(
  input  logic [TILE_LG-1:0] din,
  input  logic [2:0]         swz,
  output logic [TILE_LG-1:0] dout
);
  logic flip;

  always_comb begin
    unique case (swz)
      SWZ_B9:     flip = din[9];
      SWZ_B9_10:  flip = din[9] ^ din[10];
      SWZ_B9_11:  flip = din[9] ^ din[11];
      SWZ_B9_ALL: flip = din[9] ^ din[10] ^ din[11];
      default:    flip = 1'b0;
    endcase
    dout    = din;
    dout[6] = din[6] ^ flip;
  end
endmodule

// File: rtl/tile_addr_gen.sv
module tile_addr_gen
  import tile_addr_pkg::*;
#(
  parameter int COORD_W = 14,
  parameter int PITCH_W = 14,
  parameter int OFF_W   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [COORD_W-1:0] in_x,
  input  logic [COORD_W-1:0] in_y,
  input  logic [PITCH_W-1:0] in_pitch,
  input  logic [1:0]         in_bpp,
  input  logic [1:0]         in_layout,
  input  logic [2:0]         in_swz,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [OFF_W-1:0]   out_off,
  output logic               out_err
);
  localparam int XB_W = COORD_W + 2;
  localparam int RB_W = PITCH_W + 2;

  logic [XB_W-1:0]    f_xbyte;
  logic [RB_W-1:0]    f_rowbytes;
  logic               f_bad;

  logic               s1_valid;
  logic [XB_W-1:0]    s1_xbyte;
  logic [COORD_W-1:0] s1_y;
  logic [RB_W-1:0]    s1_rowbytes;
  req_mode_t          s1_mode;

  logic               adv2;
  logic [TILE_LG-1:0] wide_in, tall_in, wide_sw, tall_sw;
  logic [OFF_W-1:0]   wide_base, tall_base, lin_off, next_off;

  tile_addr_front #(.COORD_W(COORD_W), .PITCH_W(PITCH_W)) u_front (
    .x(in_x), .pitch(in_pitch), .bpp(in_bpp), .layout(in_layout),
    .swz(in_swz), .xbyte(f_xbyte), .rowbytes(f_rowbytes), .bad(f_bad)
  );

  assign adv2     = !out_valid || out_ready;
  assign in_ready = !s1_valid || adv2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
    end else if (in_ready) begin
      s1_valid <= in_valid;
    end
    if (in_ready && in_valid) begin
      s1_xbyte    <= f_xbyte;
      s1_y        <= in_y;
      s1_rowbytes <= f_rowbytes;
      s1_mode     <= '{layout: in_layout, swz: in_swz, err: f_bad};
    end
  end

  tile_addr_geom #(.XB_W(XB_W), .Y_W(COORD_W), .RB_W(RB_W), .OFF_W(OFF_W),
                   .SPAN_LG(9), .ROWS_LG(3), .BLOCK_LG(0)) u_wide (
    .xbyte(s1_xbyte), .y(s1_y), .rowbytes(s1_rowbytes),
    .intile(wide_in), .base(wide_base)
  );

  tile_addr_geom #(.XB_W(XB_W), .Y_W(COORD_W), .RB_W(RB_W), .OFF_W(OFF_W),
                   .SPAN_LG(7), .ROWS_LG(5), .BLOCK_LG(4)) u_tall (
    .xbyte(s1_xbyte), .y(s1_y), .rowbytes(s1_rowbytes),
    .intile(tall_in), .base(tall_base)
  );

  tile_addr_swz u_swz_wide (.din(wide_in), .swz(s1_mode.swz), .dout(wide_sw));
  tile_addr_swz u_swz_tall (.din(tall_in), .swz(s1_mode.swz), .dout(tall_sw));

  always_comb begin
    lin_off = OFF_W'(s1_y) * OFF_W'(s1_rowbytes) + OFF_W'(s1_xbyte);
    if (s1_mode.err) begin
      next_off = '0;
    end else begin
      unique case (s1_mode.layout)
        LAYOUT_WIDE: next_off = wide_base + OFF_W'(wide_sw);
        LAYOUT_TALL: next_off = tall_base + OFF_W'(tall_sw);
        default:     next_off = lin_off;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_off   <= '0;
      out_err   <= 1'b0;
    end else if (adv2) begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_off <= next_off;
        out_err <= s1_mode.err;
      end
    end
  end
endmodule

// File: rtl/tile_addr_chk.sv
module tile_addr_chk #(
  parameter int OFF_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OFF_W-1:0] out_off,
  input logic             out_err
);
  // R7: an erroneous result carries a zero offset
  p_err_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_err) |-> (out_off == '0));

  // R8: two-cycle latency when the consumer is ready
  p_latency_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) ##1 out_ready |=> out_valid);

  // R9: a stalled result holds
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_off) && $stable(out_err)));

  // R9: a ready consumer never blocks the input
  p_ready_r9: assert property (@(posedge clk) disable iff (rst)
    out_ready |-> in_ready);
endmodule

bind tile_addr_gen tile_addr_chk #(.OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_off(out_off),
  .out_err(out_err)
);

// File: tb/test_tile_addr_gen.sv
module test_tile_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 15;

  // fields: x[81:68] y[67:54] pitch[53:40] bpp[39:38] layout[37:36] swz[35:33] off[32:1] err[0]
  localparam logic [81:0] VEC [NVEC] = '{
    {14'd5,   14'd3,  14'd100,  2'd2, 2'd0, 3'd0, 32'd1220,  1'b0},
    {14'd7,   14'd0,  14'd64,   2'd1, 2'd0, 3'd0, 32'd14,    1'b0},
    {14'd130, 14'd11, 14'd256,  2'd2, 2'd1, 3'd0, 32'd13832, 1'b0},
    {14'd130, 14'd11, 14'd256,  2'd2, 2'd1, 3'd1, 32'd13896, 1'b0},
    {14'd130, 14'd11, 14'd256,  2'd2, 2'd1, 3'd2, 32'd13832, 1'b0},
    {14'd130, 14'd11, 14'd256,  2'd2, 2'd1, 3'd3, 32'd13896, 1'b0},
    {14'd130, 14'd11, 14'd256,  2'd2, 2'd1, 3'd4, 32'd13832, 1'b0},
    {14'd200, 14'd40, 14'd512,  2'd0, 2'd2, 3'd0, 32'd22664, 1'b0},
    {14'd200, 14'd40, 14'd512,  2'd0, 2'd2, 3'd3, 32'd22728, 1'b0},
    {14'd200, 14'd40, 14'd512,  2'd0, 2'd2, 3'd4, 32'd22728, 1'b0},
    {14'd9,   14'd9,  14'd64,   2'd0, 2'd3, 3'd0, 32'd0,     1'b1},
    {14'd130, 14'd11, 14'd256,  2'd2, 2'd1, 3'd6, 32'd0,     1'b1},
    {14'd5,   14'd3,  14'd100,  2'd3, 2'd0, 3'd0, 32'd0,     1'b1},
    {14'd600, 14'd0,  14'd1000, 2'd0, 2'd0, 3'd1, 32'd600,   1'b0},
    {14'd576, 14'd1,  14'd1024, 2'd0, 2'd1, 3'd1, 32'd4608,  1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [13:0] in_x = '0, in_y = '0, in_pitch = '0;
  logic [1:0]  in_bpp = '0, in_layout = '0;
  logic [2:0]  in_swz = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_off;
  logic        out_err;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tile_addr_gen i_tile_addr_gen (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y), .in_pitch(in_pitch), .in_bpp(in_bpp),
    .in_layout(in_layout), .in_swz(in_swz), .out_valid(out_valid),
    .out_ready(out_ready), .out_off(out_off), .out_err(out_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load(input logic [81:0] v);
    in_x      = v[81:68];
    in_y      = v[67:54];
    in_pitch  = v[53:40];
    in_bpp    = v[39:38];
    in_layout = v[37:36];
    in_swz    = v[35:33];
  endtask

  function automatic string tag_of(input logic [81:0] v);
    if (v[0]) return "R7";
    if (v[37:36] == 2'd0) return (v[35:33] != 3'd0) ? "R6" : "R2";
    if (v[35:33] != 3'd0) return "R5";
    return (v[37:36] == 2'd1) ? "R3" : "R4";
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 out_valid", 32'(out_valid), 32'd0);
    chk("R1 in_ready", 32'(in_ready), 32'd1);

    for (int i = 0; i < NVEC; i++) begin
      load(VEC[i]);
      in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      chk("R8 early valid", 32'(out_valid), 32'd0);
      @(posedge clk);
      @(negedge clk);
      chk("R8 valid", 32'(out_valid), 32'd1);
      chk(tag_of(VEC[i]), out_off, VEC[i][32:1]);
      chk({tag_of(VEC[i]), " err"}, 32'(out_err), 32'(VEC[i][0]));
    end

    // R9 backpressure: two requests, output stalled
    @(negedge clk);
    out_ready = 1'b0;
    load(VEC[0]);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    load(VEC[2]);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 first out", out_off, VEC[0][32:1]);
    chk("R9 in_ready low", 32'(in_ready), 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R9 hold valid", 32'(out_valid), 32'd1);
    chk("R9 hold", out_off, VEC[0][32:1]);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R9 second out", out_off, VEC[2][32:1]);
    chk("R9 second valid", 32'(out_valid), 32'd1);
    @(posedge clk);
    @(negedge clk);
    chk("R9 drained", 32'(out_valid), 32'd0);

    // R1 reset clears a pending result
    load(VEC[1]);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset flush", 32'(out_valid), 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R1 reset flush late", 32'(out_valid), 32'd0);

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule